// File: doc/BRIEF.md
# Instruction cycle timing sequencer

This block produces the per-cycle timing flags of a small 8-bit processor. Each cycle exactly one main state is active. Two states lag the others: the operation state `t0` and the write-back state `t1`. They come after the addressing states `t2`..`t5` of an instruction. A separate fetch flag `t1f` marks the cycle that fetches the second instruction byte, and the `sync` output repeats it. Read-modify-write instructions add two store cycles, `sd1` and `sd2`. The break sequence adds vector cycles `vec0` and `vec1`.

An opcode classifier inside the block looks at the current opcode byte. It decides on which cycle the instruction returns to `t0`. Two further inputs can shorten the sequence: one reports a page crossing and one reports the branch outcome. The `rdy` input stalls read cycles. Write cycles go ahead regardless, and `t1` is never held.

Top module: `cycle_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is `t0`, with every other flag and `sync` low.
- R2: An opcode is a two-cycle opcode when it matches xxx010x1, 1xx000x0 or xxxx10x0 and does not match 0xx01000. From `t1f` such an opcode goes straight to `t0` and never enters `t2`.
- R3: Some opcodes return to `t0` after a fixed addressing cycle: push 0x001000 after `t2`, pull 0x101000 after `t3`, jump 01001100 after `t2`, indirect jump 01101100 after `t4`, and call 00100000 or return 01x00000 after `t5`.
- R4: Any other opcode is a memory opcode. Its last addressing cycle is set by bits 4:2: 001 gives `t2`, 011 and 101 give `t3`, 11x gives `t4`, and x00 gives `t5`. The `t0` state follows that last cycle.
- R5: Some memory opcodes enter `t0` one cycle early when `page_cross` is low. This applies when bits 4:3 are 11 or bits 4:2 are 100, and the opcode is neither a store (bits 7:5 = 100) nor a read-modify-write.
- R6: A read-modify-write opcode is a memory opcode with bit 1 set and bits 7:6 not 10. After its last addressing cycle it runs `sd1`, then `sd2`, then `t0`.
- R7: For the break opcode 00000000, `vec0` is high while `t5` and `rdy` are both high. `vec1` follows in the next cycle, and `t0` follows `vec1`.
- R8: A branch opcode xxx10000 goes from `t2` to `t1f` alone when `br_taken` is low. When taken, it goes `t2`, `t3`, `t1f` if `page_cross` is low, and `t2`, `t3`, `t0`, `t1f`+`t1` if `page_cross` is high.
- R9: When `rdy` is high, `t0` is followed by `t1f` together with `t1`. `t1` lasts one cycle only. If `rdy` is low in that cycle, `t1f` alone follows and holds until `rdy` rises.
- R10: Low `rdy` holds `t0`, `vec1` and every read addressing cycle. Write cycles advance anyway: the last addressing cycle of a store, `t2` of a push, `sd1` and `sd2`.
- R11: `sync` equals `t1f` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rdy | input | 1 | Ready; low stalls read cycles |
| opcode | input | 8 | Opcode of the current instruction |
| page_cross | input | 1 | Indexed or branch address crossed a page |
| br_taken | input | 1 | Branch condition is true |
| t0 | output | 1 | Operation state |
| t1 | output | 1 | Write-back state, one cycle |
| t1f | output | 1 | Second-byte fetch state |
| t2 | output | 1 | Addressing cycle 2 |
| t3 | output | 1 | Addressing cycle 3 |
| t4 | output | 1 | Addressing cycle 4 |
| t5 | output | 1 | Addressing cycle 5 |
| sd1 | output | 1 | First read-modify-write store cycle |
| sd2 | output | 1 | Second read-modify-write store cycle |
| vec0 | output | 1 | Low vector byte fetch |
| vec1 | output | 1 | High vector byte fetch |
| sync | output | 1 | Fetch strobe, equal to t1f |

## Verification
The bench targets the places where the sequence length depends on small opcode and input details. These are the early exit of indexed loads against the full length of indexed stores, and the three lengths of a branch. A wrong decode at either place gives instructions one cycle too long or too short. Stalls are placed on `t1`, on read cycles and on write cycles. A design that froze a write cycle would hang a bus write, and one that held `t1` would repeat the write-back. The break opcode is stalled in `t5` to show that `vec0` waits for ready. A reset in the middle of an instruction must give `t0` on the next edge.

// File: rtl/cycle_seq.sv
module cycle_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       rdy,
  input  logic [7:0] opcode,
  input  logic       page_cross,
  input  logic       br_taken,
  output logic       t0,
  output logic       t1,
  output logic       t1f,
  output logic       t2,
  output logic       t3,
  output logic       t4,
  output logic       t5,
  output logic       sd1,
  output logic       sd2,
  output logic       vec0,
  output logic       vec1,
  output logic       sync
);

  typedef enum logic [3:0] {
    S_T0, S_T1A, S_T1B, S_T2, S_T3, S_T4, S_T5, S_SD1, S_SD2, S_VEC1
  } st_e;

  st_e st, nx;
  logic [3:0] st_v;
  logic [2:0] step, tmem, last;

  logic two, push, pull, jmp, jmpi, jsr, ret, brk, br;
  logic is_mem, store, rmw, early_ok, in_addr, wr_cycle;

  assign two  = (((opcode & 8'h1D) == 8'h09) || ((opcode & 8'h9D) == 8'h80) ||
                 ((opcode & 8'h0D) == 8'h08)) && ((opcode & 8'h9F) != 8'h08);
  assign push = (opcode & 8'hBF) == 8'h08;
  assign pull = (opcode & 8'hBF) == 8'h28;
  assign jmp  = opcode == 8'h4C;
  assign jmpi = opcode == 8'h6C;
  assign jsr  = opcode == 8'h20;
  assign ret  = (opcode & 8'hDF) == 8'h40;
  assign brk  = opcode == 8'h00;
  assign br   = (opcode & 8'h1F) == 8'h10;

  assign is_mem   = !(two || push || pull || jmp || jmpi || jsr || ret || brk || br);
  assign store    = is_mem && opcode[7:5] == 3'b100;
  assign rmw      = is_mem && opcode[1] && opcode[7:6] != 2'b10;
  assign early_ok = is_mem && !store && !rmw &&
                    (opcode[4:3] == 2'b11 || opcode[4:2] == 3'b100);

  always_comb begin
    case (opcode[4:2])
      3'b001:          tmem = 3'd2;
      3'b011, 3'b101:  tmem = 3'd3;
      3'b110, 3'b111:  tmem = 3'd4;
      default:         tmem = 3'd5;
    endcase
  end

  always_comb begin
    if (push || jmp)            last = 3'd2;
    else if (pull || br)        last = 3'd3;
    else if (jmpi)              last = 3'd4;
    else if (jsr || ret || brk) last = 3'd5;
    else                        last = tmem;
  end

  assign st_v     = st;
  assign step     = st_v[2:0] - 3'd1;
  assign in_addr  = st == S_T2 || st == S_T3 || st == S_T4 || st == S_T5;
  assign wr_cycle = (in_addr && ((store && step == tmem) || (push && step == 3'd2))) ||
                    st == S_SD1 || st == S_SD2;

  always_comb begin
    nx = st;
    case (st)
      S_T0:         if (rdy) nx = S_T1A;
      S_T1A, S_T1B: if (!rdy) nx = S_T1B;
                    else nx = two ? S_T0 : S_T2;
      S_T2, S_T3, S_T4, S_T5:
        if (rdy || wr_cycle) begin
          if (br)
            nx = (st == S_T2) ? (br_taken ? S_T3 : S_T1B) : (page_cross ? S_T0 : S_T1B);
          else if (brk && st == S_T5)                        nx = S_VEC1;
          else if (rmw && step == tmem)                      nx = S_SD1;
          else if (step == last)                             nx = S_T0;
          else if (early_ok && !page_cross && step + 3'd1 == tmem) nx = S_T0;
          else                                               nx = st_e'(st_v + 4'd1);
        end
      S_SD1:  nx = S_SD2;
      S_SD2:  nx = S_T0;
      S_VEC1: if (rdy) nx = S_T0;
      default: nx = S_T0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_T0;
    else     st <= nx;
  end

  assign t0   = st == S_T0;
  assign t1   = st == S_T1A;
  assign t1f  = st == S_T1A || st == S_T1B;
  assign t2   = st == S_T2;
  assign t3   = st == S_T3;
  assign t4   = st == S_T4;
  assign t5   = st == S_T5;
  assign sd1  = st == S_SD1;
  assign sd2  = st == S_SD2;
  assign vec1 = st == S_VEC1;
  assign vec0 = t5 && rdy && brk;
  assign sync = t1f;

  // R1
  rst_to_t0_chk: assert property (@(posedge clk) rst |=> t0);
  // R9
  t1_once_chk: assert property (@(posedge clk) disable iff (rst) t1 |=> !t1);
  // R9
  t1_entry_chk: assert property (@(posedge clk) disable iff (rst) t1 |-> $past(t0 && rdy));
  // R2
  two_cyc_chk: assert property (@(posedge clk) disable iff (rst) (t1f && rdy && two) |=> t0);
  // R6
  sd_chain_chk: assert property (@(posedge clk) disable iff (rst) sd1 |=> sd2);
  // R6
  sd_exit_chk: assert property (@(posedge clk) disable iff (rst) sd2 |=> t0);
  // R7
  vec_follow_chk: assert property (@(posedge clk) disable iff (rst) vec0 |=> vec1);
  // R10
  t0_hold_chk: assert property (@(posedge clk) disable iff (rst) (t0 && !rdy) |=> t0);

endmodule

// File: tb/cycle_seq_tb.sv
module cycle_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rdy = 1'b1;
  logic [7:0] opcode = 8'hEA;
  logic page_cross = 1'b0;
  logic br_taken = 1'b0;
  logic t0, t1, t1f, t2, t3, t4, t5, sd1, sd2, vec0, vec1, sync;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cycle_seq u_dut (
    .clk(clk), .rst(rst), .rdy(rdy), .opcode(opcode), .page_cross(page_cross),
    .br_taken(br_taken), .t0(t0), .t1(t1), .t1f(t1f), .t2(t2), .t3(t3), .t4(t4),
    .t5(t5), .sd1(sd1), .sd2(sd2), .vec0(vec0), .vec1(vec1), .sync(sync)
  );

  // {req id, opcode, page_cross, br_taken, trace of 8 state codes from t0}
  // codes: 0 t0, 1 t1f+t1, 2 t1f, 3 t2, 4 t3, 5 t4, 6 t5, 7 sd1, 8 sd2, 9 vec1, A t5+vec0
  localparam logic [45:0] TBL [26] = '{
    {4'd2, 8'hA9, 1'b0, 1'b0, 32'h01010101},
    {4'd2, 8'hEA, 1'b0, 1'b0, 32'h01010101},
    {4'd2, 8'hA2, 1'b0, 1'b0, 32'h01010101},
    {4'd3, 8'h48, 1'b0, 1'b0, 32'h01301301},
    {4'd3, 8'h68, 1'b0, 1'b0, 32'h01340134},
    {4'd3, 8'h4C, 1'b0, 1'b0, 32'h01301301},
    {4'd3, 8'h6C, 1'b0, 1'b0, 32'h01345013},
    {4'd3, 8'h20, 1'b0, 1'b0, 32'h01345601},
    {4'd3, 8'h60, 1'b0, 1'b0, 32'h01345601},
    {4'd3, 8'h40, 1'b0, 1'b0, 32'h01345601},
    {4'd7, 8'h00, 1'b0, 1'b0, 32'h01345A90},
    {4'd4, 8'hA5, 1'b0, 1'b0, 32'h01301301},
    {4'd4, 8'hAD, 1'b0, 1'b0, 32'h01340134},
    {4'd4, 8'hB5, 1'b0, 1'b0, 32'h01340134},
    {4'd4, 8'hBD, 1'b1, 1'b0, 32'h01345013},
    {4'd5, 8'hBD, 1'b0, 1'b0, 32'h01340134},
    {4'd5, 8'h9D, 1'b0, 1'b0, 32'h01345013},
    {4'd5, 8'hB1, 1'b0, 1'b0, 32'h01345013},
    {4'd4, 8'hB1, 1'b1, 1'b0, 32'h01345601},
    {4'd4, 8'hA1, 1'b0, 1'b0, 32'h01345601},
    {4'd6, 8'h06, 1'b0, 1'b0, 32'h01378013},
    {4'd6, 8'hFE, 1'b0, 1'b0, 32'h01345780},
    {4'd8, 8'hD0, 1'b0, 1'b0, 32'h01323232},
    {4'd8, 8'hD0, 1'b0, 1'b1, 32'h01342342},
    {4'd8, 8'hD0, 1'b1, 1'b1, 32'h01340134},
    {4'd4, 8'h85, 1'b0, 1'b0, 32'h01301301}
  };

  function automatic string rname(input int id);
    case (id)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; default: return "R11";
    endcase
  endfunction

  function automatic logic [3:0] obs();
    if ($countones({t0, t1f, t2, t3, t4, t5, sd1, sd2, vec1}) != 1) return 4'hF;
    if (t5 && vec0) return 4'hA;
    if (t0) return 4'h0;
    if (t1f && t1) return 4'h1;
    if (t1f) return 4'h2;
    if (t2) return 4'h3;
    if (t3) return 4'h4;
    if (t4) return 4'h5;
    if (t5) return 4'h6;
    if (sd1) return 4'h7;
    if (sd2) return 4'h8;
    return 4'h9;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_code(input logic [3:0] c, input string req);
    chk(obs() == c && sync == t1f, req, {27'd0, sync, obs()}, {28'd0, c});
  endtask

  task automatic restart(input logic [7:0] op, input logic pc, input logic bt);
    @(negedge clk);
    rst = 1'b1; rdy = 1'b1; opcode = op; page_cross = pc; br_taken = bt;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] tr;
    // R1 reset state
    restart(8'hEA, 1'b0, 1'b0);
    chk({t0, t1, t1f, t2, t3, t4, t5, sd1, sd2, vec0, vec1, sync} == 12'h800, "R1",
        {20'd0, t0, t1, t1f, t2, t3, t4, t5, sd1, sd2, vec0, vec1, sync}, 32'h800);

    for (int i = 0; i < 26; i++) begin
      restart(TBL[i][41:34], TBL[i][33], TBL[i][32]);
      tr = '0;
      for (int k = 0; k < 8; k++) begin
        tr = {tr[27:0], obs()};
        if (sync != t1f) tr[3:0] = 4'hE;  // R11
        @(negedge clk);
      end
      chk(tr == TBL[i][31:0], rname(int'(TBL[i][45:42])), tr, TBL[i][31:0]);
    end

    // R9 / R10: stalls around fetch and read cycles, lda abs
    restart(8'hAD, 1'b0, 1'b0);
    rdy = 1'b0; @(negedge clk); expect_code(4'h0, "R10");
    rdy = 1'b1; @(negedge clk); expect_code(4'h1, "R9");
    chk(sync, "R11", {31'd0, sync}, 32'd1);
    rdy = 1'b0; @(negedge clk); expect_code(4'h2, "R9");
    @(negedge clk); expect_code(4'h2, "R9");
    rdy = 1'b1; @(negedge clk); expect_code(4'h3, "R9");
    rdy = 1'b0; @(negedge clk); expect_code(4'h3, "R10");
    rdy = 1'b1; @(negedge clk); expect_code(4'h4, "R10");
    rdy = 1'b0; @(negedge clk); expect_code(4'h4, "R10");
    rdy = 1'b1; @(negedge clk); expect_code(4'h0, "R4");

    // R10: store write cycle ignores stall (sta zp)
    restart(8'h85, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk); expect_code(4'h3, "R4");
    rdy = 1'b0; @(negedge clk); expect_code(4'h0, "R10");

    // R10: push write in t2 ignores stall
    restart(8'h48, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk);
    rdy = 1'b0; @(negedge clk); expect_code(4'h0, "R10");

    // R6 / R10: sd1 and sd2 advance while stalled (asl zp)
    restart(8'h06, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk); @(negedge clk); expect_code(4'h7, "R6");
    rdy = 1'b0; @(negedge clk); expect_code(4'h8, "R10");
    @(negedge clk); expect_code(4'h0, "R10");

    // R7: vec0 waits for ready in t5
    restart(8'h00, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    expect_code(4'hA, "R7");
    rdy = 1'b0; #1;
    chk(t5 && !vec0, "R7", {30'd0, t5, vec0}, 32'h2);
    @(negedge clk); expect_code(4'h6, "R10");
    rdy = 1'b1; #1;
    chk(t5 && vec0, "R7", {30'd0, t5, vec0}, 32'h3);
    @(negedge clk); expect_code(4'h9, "R7");
    rdy = 1'b0; @(negedge clk); expect_code(4'h9, "R10");
    rdy = 1'b1; @(negedge clk); expect_code(4'h0, "R7");

    // R1: reset in the middle of an instruction
    restart(8'hBD, 1'b1, 1'b0);
    @(negedge clk); @(negedge clk); @(negedge clk); expect_code(4'h4, "R4");
    rst = 1'b1; @(negedge clk); expect_code(4'h0, "R1");
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule